// File: doc/BRIEF.md
# Ethernet receive frame qualifier

This block sits between the byte-wide receive path of an 802.3 MAC and a receive FIFO. For each carrier event it skips the preamble, locks onto the start-of-frame delimiter, and streams the frame bytes that follow into the FIFO. While bytes arrive it keeps a running CRC-32, captures the length/type field, and applies automatic pad removal when a short frame carries an 802.3 length.

The frame ends when carrier drops. The block then issues a single-cycle commit strobe, with a status word that gives the received length, a CRC error flag and a pad-stripped flag. It issues a discard strobe instead when the frame is a runt, or when a collision occurred early in the frame. On a discard the FIFO rolls back its write pointer, so rejected frames reach no consumer and no status is produced for them.

Top module: `eth_rx_qual`

## Requirements
- R1: While out of a frame, receive bytes of value 0x55 are skipped. The first byte of value 0xD5 starts a frame, and the byte after it is frame byte 0. Any other byte seen before 0xD5 makes the block ignore the rest of that carrier event: no writes and no strobe.
- R2: Each frame byte accepted while rx_crs and rx_dv are high, and not suppressed, appears on fifo_data with fifo_wr high one clock later, in arrival order.
- R3: The CRC-32 (reflected polynomial 0xEDB88320, preset all ones) runs over every frame byte, including pad and FCS. The FCS is the inverted CRC, sent least significant byte first. stat_crc_err is high at commit exactly when the check fails.
- R4: Without pad stripping, every frame byte including the 4 FCS bytes is forwarded, and stat_frame_len equals the number of frame bytes received.
- R5: With cfg_strip_pad high and a length field L in 1..45, only frame bytes 0..13+L are forwarded. The CRC still covers the whole stream, and stat_pad_stripped is high at commit.
- R6: The length/type field is frame bytes 12 (high) and 13 (low). A value of 0 or above 1500 is a type, and the frame is never stripped. A length of 46 or more is not stripped either.
- R7: If carrier drops with fewer than 64 frame bytes received, the block gives a discard strobe and no commit, unless cfg_accept_runt is high, in which case it commits. A 64-byte frame commits.
- R8: A collision (rx_col high during carrier) while fewer than 64 frame bytes have been accepted gives a discard strobe one cycle later. The rest of the carrier event is then ignored. A collision after 64 bytes has no effect.
- R9: The commit or discard strobe comes one cycle after carrier drops in a frame. There is exactly one strobe per frame. The two strobes are never high together, and neither coincides with a write.
- R10: After reset, fifo_wr, fifo_commit, fifo_discard and all status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_crs | input | 1 | Carrier present; its fall ends a frame |
| rx_dv | input | 1 | Receive byte valid this cycle |
| rx_data | input | 8 | Receive byte |
| rx_col | input | 1 | Collision indication |
| cfg_strip_pad | input | 1 | Enable automatic pad and FCS removal |
| cfg_accept_runt | input | 1 | Commit frames shorter than 64 bytes |
| fifo_wr | output | 1 | FIFO byte write |
| fifo_data | output | 8 | FIFO write byte |
| fifo_commit | output | 1 | Frame accepted; status valid this cycle |
| fifo_discard | output | 1 | Roll back the frame written so far |
| stat_frame_len | output | 12 | Frame bytes received (saturating) |
| stat_crc_err | output | 1 | FCS mismatch |
| stat_pad_stripped | output | 1 | Pad and FCS were withheld |

## Verification
On every cycle the assertions check the strobe rules: the two strobes are exclusive, no write shares a cycle with a strobe, and the cycle after a strobe is quiet. They also check the one-cycle write latency, the runt gate on commits, and that the number of bytes written matches the reported length (equal when not stripped, smaller when stripped). Byte contents, CRC verdicts, where pad removal cuts off, the collision window boundary and preamble rejection depend on what each frame carries. The bench's directed and random frames show these against lists of expected values it builds for itself.

// File: rtl/eth_rx_qual_pkg.sv
package eth_rx_qual_pkg;

    localparam int LEN_W      = 12;
    localparam int HDR_BYTES  = 14;
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    // Reflected form of 0x04C11DB7; the good-frame residue 0xDEBB20E3 is the
    // reflected-register counterpart of the MSB-first value 0xC704DD7B.
    localparam logic [31:0] CRC_POLY_R    = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE_R = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FRAME = 2'd1,
        ST_DROP  = 2'd2
    } rxq_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] frame_len;
        logic             crc_err;
        logic             pad_stripped;
    } rxq_status_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  b);
        logic [31:0] c;
        c = crc_in ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
    import eth_rx_qual_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic       crc_good
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

    assign crc_good = (crc_q == CRC_RESIDUE_R);
endmodule

// File: rtl/eth_rx_pad_ctl.sv
module eth_rx_pad_ctl
    import eth_rx_qual_pkg::*;
#(
    parameter int MAX_LEN     = 1500,
    parameter int MIN_PAYLOAD = 46
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       din,
    input  logic             strip_en,
    output logic             suppress,
    output logic             padded
);
    localparam logic [LEN_W-1:0] IDX_HI = LEN_W'(HDR_BYTES - 2);
    localparam logic [LEN_W-1:0] IDX_LO = LEN_W'(HDR_BYTES - 1);

    logic [15:0] len_q;
    logic        have_len;
    logic        is_length;
    logic [16:0] keep_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len_q    <= '0;
            have_len <= 1'b0;
        end else if (en) begin
            if (idx == IDX_HI) len_q[15:8] <= din;
            if (idx == IDX_LO) begin
                len_q[7:0] <= din;
                have_len   <= 1'b1;
            end
        end
    end

    assign is_length = have_len && (len_q != 16'd0) && (len_q <= 16'(MAX_LEN));
    assign padded    = strip_en && is_length && (len_q < 16'(MIN_PAYLOAD));
    assign keep_end  = 17'(HDR_BYTES) + {1'b0, len_q};
    assign suppress  = padded && (17'(idx) >= keep_end);
endmodule

// File: rtl/eth_rx_qual.sv
module eth_rx_qual
    import eth_rx_qual_pkg::*;
#(
    parameter int MIN_FRAME   = 64,
    parameter int COL_WINDOW  = 64,
    parameter int MAX_LEN     = 1500,
    parameter int MIN_PAYLOAD = 46
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_crs,
    input  logic             rx_dv,
    input  logic [7:0]       rx_data,
    input  logic             rx_col,
    input  logic             cfg_strip_pad,
    input  logic             cfg_accept_runt,
    output logic             fifo_wr,
    output logic [7:0]       fifo_data,
    output logic             fifo_commit,
    output logic             fifo_discard,
    output logic [LEN_W-1:0] stat_frame_len,
    output logic             stat_crc_err,
    output logic             stat_pad_stripped
);
    localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] COL_LIM  = LEN_W'(COL_WINDOW);
    localparam logic [LEN_W-1:0] CNT_MAX  = '1;

    rxq_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    rxq_status_t      stat_q;

    logic in_frame, sfd_hit, col_kill, byte_acc, crc_good, suppress, padded;

    assign in_frame = (state_q == ST_FRAME) && rx_crs;
    assign sfd_hit  = (state_q == ST_HUNT) && rx_crs && rx_dv && (rx_data == SFD_BYTE);
    assign col_kill = in_frame && rx_col && (cnt_q < COL_LIM);
    assign byte_acc = in_frame && rx_dv && !col_kill;

    eth_rx_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .clr      (sfd_hit),
        .en       (byte_acc),
        .din      (rx_data),
        .crc_good (crc_good)
    );

    eth_rx_pad_ctl #(
        .MAX_LEN     (MAX_LEN),
        .MIN_PAYLOAD (MIN_PAYLOAD)
    ) u_pad (
        .clk      (clk),
        .rst      (rst),
        .clr      (sfd_hit),
        .en       (byte_acc),
        .idx      (cnt_q),
        .din      (rx_data),
        .strip_en (cfg_strip_pad),
        .suppress (suppress),
        .padded   (padded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_HUNT;
            cnt_q        <= '0;
            stat_q       <= '0;
            fifo_wr      <= 1'b0;
            fifo_data    <= '0;
            fifo_commit  <= 1'b0;
            fifo_discard <= 1'b0;
        end else begin
            fifo_wr      <= 1'b0;
            fifo_commit  <= 1'b0;
            fifo_discard <= 1'b0;
            case (state_q)
                ST_HUNT: begin
                    if (sfd_hit) begin
                        state_q <= ST_FRAME;
                        cnt_q   <= '0;
                    end else if (rx_crs && rx_dv && (rx_data != PRE_BYTE)) begin
                        state_q <= ST_DROP;
                    end
                end
                ST_FRAME: begin
                    if (!rx_crs) begin
                        state_q <= ST_HUNT;
                        if ((cnt_q < RUNT_LIM) && !cfg_accept_runt) begin
                            fifo_discard <= 1'b1;
                        end else begin
                            fifo_commit         <= 1'b1;
                            stat_q.frame_len    <= cnt_q;
                            stat_q.crc_err      <= !crc_good;
                            stat_q.pad_stripped <= padded;
                        end
                    end else if (col_kill) begin
                        state_q      <= ST_DROP;
                        fifo_discard <= 1'b1;
                    end else if (byte_acc) begin
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                        if (!suppress) begin
                            fifo_wr   <= 1'b1;
                            fifo_data <= rx_data;
                        end
                    end
                end
                ST_DROP: begin
                    if (!rx_crs) state_q <= ST_HUNT;
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    assign stat_frame_len    = stat_q.frame_len;
    assign stat_crc_err      = stat_q.crc_err;
    assign stat_pad_stripped = stat_q.pad_stripped;
endmodule

// File: rtl/eth_rx_qual_chk.sv
module eth_rx_qual_chk
    import eth_rx_qual_pkg::*;
#(
    parameter int MIN_FRAME = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_crs,
    input logic             rx_dv,
    input logic             cfg_accept_runt,
    input logic             fifo_wr,
    input logic             fifo_commit,
    input logic             fifo_discard,
    input logic [LEN_W-1:0] stat_frame_len,
    input logic             stat_pad_stripped
);
    logic [LEN_W-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (rst || fifo_commit || fifo_discard) wr_cnt <= '0;
        else if (fifo_wr && wr_cnt != '1)        wr_cnt <= wr_cnt + 1'b1;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_commit && fifo_discard)); // R9
    AST_NO_WR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (fifo_commit || fifo_discard) |-> !fifo_wr); // R9
    AST_QUIET_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (fifo_commit || fifo_discard) |=> !(fifo_wr || fifo_commit || fifo_discard)); // R9
    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(rx_crs && rx_dv)); // R2
    AST_RUNT_GATE: assert property (@(posedge clk) disable iff (rst)
        (fifo_commit && !$past(cfg_accept_runt)) |-> (stat_frame_len >= LEN_W'(MIN_FRAME))); // R7
    AST_FULL_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (fifo_commit && !stat_pad_stripped) |-> (wr_cnt == stat_frame_len)); // R4
    AST_STRIP_SHORTER: assert property (@(posedge clk) disable iff (rst)
        (fifo_commit && stat_pad_stripped) |-> (wr_cnt < stat_frame_len)); // R5
endmodule

bind eth_rx_qual eth_rx_qual_chk #(.MIN_FRAME(MIN_FRAME)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .rx_crs            (rx_crs),
    .rx_dv             (rx_dv),
    .cfg_accept_runt   (cfg_accept_runt),
    .fifo_wr           (fifo_wr),
    .fifo_commit       (fifo_commit),
    .fifo_discard      (fifo_discard),
    .stat_frame_len    (stat_frame_len),
    .stat_pad_stripped (stat_pad_stripped)
);

// File: tb/eth_rx_qual_test.sv
`timescale 1ns/1ps
module eth_rx_qual_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_crs = 1'b0, rx_dv = 1'b0, rx_col = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cfg_strip_pad = 1'b0, cfg_accept_runt = 1'b0;
    logic        fifo_wr, fifo_commit, fifo_discard, stat_crc_err, stat_pad_stripped;
    logic [7:0]  fifo_data;
    logic [11:0] stat_frame_len;

    int n_checks = 0, n_fail = 0;
    logic [7:0] tx_q[$];
    logic [7:0] got_q[$];
    int n_commit = 0, n_discard = 0;
    int last_len = 0;
    bit last_err = 0, last_strip = 0;

    always #2.5 clk = ~clk;

    eth_rx_qual uut (
        .clk(clk), .rst(rst), .rx_crs(rx_crs), .rx_dv(rx_dv), .rx_data(rx_data),
        .rx_col(rx_col), .cfg_strip_pad(cfg_strip_pad), .cfg_accept_runt(cfg_accept_runt),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_commit(fifo_commit),
        .fifo_discard(fifo_discard), .stat_frame_len(stat_frame_len),
        .stat_crc_err(stat_crc_err), .stat_pad_stripped(stat_pad_stripped)
    );

    always @(negedge clk) begin
        if (fifo_wr) got_q.push_back(fifo_data);
        if (fifo_commit) begin
            n_commit++;
            last_len   = int'(stat_frame_len);
            last_err   = stat_crc_err;
            last_strip = stat_pad_stripped;
        end
        if (fifo_discard) n_discard++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (tx_q[i]) begin
            c = c ^ {24'd0, tx_q[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    task automatic add_fcs(input bit corrupt);
        logic [31:0] f;
        f = ~ref_crc();
        if (corrupt) f[5] = ~f[5];
        for (int k = 0; k < 4; k++) tx_q.push_back(f[8*k +: 8]);
    endtask

    task automatic build_frame(input int lt, input int npay, input bit corrupt);
        tx_q.delete();
        for (int k = 0; k < 12; k++) tx_q.push_back(8'($urandom));
        tx_q.push_back(8'(lt >> 8));
        tx_q.push_back(8'(lt));
        for (int k = 0; k < npay; k++) tx_q.push_back(8'($urandom));
        for (int k = npay; k < 46; k++) tx_q.push_back(8'h00);
        add_fcs(corrupt);
    endtask

    task automatic build_raw(input int n);
        tx_q.delete();
        for (int k = 0; k < n - 4; k++) tx_q.push_back(8'($urandom_range(0, 255)) | 8'h80);
        add_fcs(1'b0);
    endtask

    task automatic send(input int npre, input int col_at, input bit bad_pre);
        tick();
        got_q.delete();
        n_commit = 0;
        n_discard = 0;
        rx_crs = 1'b1;
        rx_dv = 1'b1;
        if (bad_pre) begin rx_data = 8'h12; tick(); end
        for (int k = 0; k < npre; k++) begin rx_data = 8'h55; tick(); end
        rx_data = 8'hD5;
        tick();
        foreach (tx_q[i]) begin
            rx_data = tx_q[i];
            rx_col = (i == col_at);
            tick();
        end
        rx_crs = 1'b0; rx_dv = 1'b0; rx_col = 1'b0;
        repeat (4) tick();
    endtask

    function automatic int exp_fwd(input int lt, input bit strip);
        if (strip && lt >= 1 && lt <= 45) return 14 + lt;
        return tx_q.size();
    endfunction

    task automatic expect_commit(input string req, input int fwd, input bit err, input bit strip);
        chk(n_commit == 1 && n_discard == 0, {req, " commit strobe"}, n_commit, 1);
        chk(got_q.size() == fwd, {req, " forwarded count"}, got_q.size(), fwd);
        begin
            int bad = 0;
            for (int k = 0; k < got_q.size() && k < tx_q.size(); k++)
                if (got_q[k] !== tx_q[k]) bad++;
            chk(bad == 0, {req, " byte contents"}, bad, 0);
        end
        chk(last_len == tx_q.size(), {req, " frame length"}, last_len, tx_q.size());
        chk(last_err == err, {req, " R3 crc flag"}, int'(last_err), int'(err));
        chk(last_strip == strip, {req, " strip flag"}, int'(last_strip), int'(strip));
    endtask

    task automatic expect_discard(input string req);
        chk(n_discard == 1 && n_commit == 0, {req, " discard strobe"}, n_discard, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        chk(!fifo_wr && !fifo_commit && !fifo_discard, "R10 strobes idle", int'(fifo_wr), 0);
        chk(stat_frame_len == 0 && !stat_crc_err && !stat_pad_stripped, "R10 status zero",
            int'(stat_frame_len), 0);

        // R2 R4 plain length frame, good FCS
        build_frame(100, 100, 0); send(7, -1, 0);
        expect_commit("R2 R4 plain", exp_fwd(100, 0), 0, 0);
        // R3 corrupted FCS
        build_frame(100, 100, 1); send(7, -1, 0);
        expect_commit("R3 bad fcs", exp_fwd(100, 0), 1, 0);
        // R5 padded frame stripped, CRC over pad still good
        cfg_strip_pad = 1'b1;
        build_frame(10, 10, 0); send(7, -1, 0);
        expect_commit("R5 strip L10", 24, 0, 1);
        build_frame(1, 1, 0); send(3, -1, 0);
        expect_commit("R5 strip L1", 15, 0, 1);
        build_frame(45, 45, 1); send(3, -1, 0);
        expect_commit("R5 strip L45 bad fcs", 59, 1, 1);
        // R6 length 46 and type field: no stripping
        build_frame(46, 46, 0); send(7, -1, 0);
        expect_commit("R6 L46", tx_q.size(), 0, 0);
        build_frame(16'h0800, 20, 0); send(7, -1, 0);
        expect_commit("R6 type", tx_q.size(), 0, 0);
        build_frame(0, 10, 0); send(7, -1, 0);
        expect_commit("R6 zero", tx_q.size(), 0, 0);
        // R4 padded frame with stripping off forwards everything
        cfg_strip_pad = 1'b0;
        build_frame(10, 10, 0); send(7, -1, 0);
        expect_commit("R4 R7 64-byte unstripped", 64, 0, 0);
        // R7 runt handling
        build_raw(63); send(7, -1, 0);
        expect_discard("R7 runt 63");
        build_raw(40); send(7, -1, 0);
        expect_discard("R7 runt 40");
        cfg_accept_runt = 1'b1;
        build_raw(40); send(7, -1, 0);
        expect_commit("R7 runt accepted", 40, 0, 0);
        cfg_accept_runt = 1'b0;
        // R8 collision window
        build_frame(100, 100, 0); send(7, 10, 0);
        expect_discard("R8 collision 10");
        build_frame(100, 100, 0); send(7, 63, 0);
        expect_discard("R8 collision 63");
        build_frame(100, 100, 0); send(7, 64, 0);
        expect_commit("R8 collision 64 ignored", tx_q.size(), 0, 0);
        // R1 bad preamble byte kills the event
        build_frame(100, 100, 0); send(7, -1, 1);
        chk(got_q.size() == 0, "R1 bad preamble writes", got_q.size(), 0);
        chk(n_commit == 0 && n_discard == 0, "R1 bad preamble strobes", n_commit + n_discard, 0);
        // R1 short preamble / direct delimiter
        build_frame(80, 80, 0); send(0, -1, 0);
        expect_commit("R1 no preamble", tx_q.size(), 0, 0);

        // random frames, R3 R4 R5 R6 R9
        for (int r = 0; r < 40; r++) begin
            int lt, np;
            bit st, cr;
            st = 1'($urandom);
            cr = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 3) == 0) begin
                lt = 16'h0600 + $urandom_range(0, 255);
                np = $urandom_range(46, 120);
            end else begin
                lt = $urandom_range(1, 200);
                np = lt;
            end
            cfg_strip_pad = st;
            build_frame(lt, np, cr);
            send($urandom_range(1, 7), -1, 0);
            expect_commit("R9 random", exp_fwd(lt, st), cr, st && lt <= 45);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule